// File: doc/BRIEF.md
# Configurable Word-Length Serial Shifter

This block moves one data word at a time through a serial link. It sends the bits of a parallel transmit word on a serial output and, in the same bit slots, samples a serial input into a parallel receive word. The word length is chosen at run time from a 4-bit length code, and a bit-order select picks most-significant-first or least-significant-first. In both directions the data is right-aligned, so the word always sits at bit 0 of the 16-bit buffer whatever its length.

A surrounding protocol engine supplies the bit-rate strobe and handles all framing. To start a transfer it pulses a start input. It then watches a busy flag, and it collects the received word on the single-cycle done pulse. Start, length and order are sampled only when a start pulse is accepted.

Top module: `serial_word_shifter`

## Requirements
- R1: Length code 0 selects a 16-bit word using buffer bits [15:0], and a code n from 4 to 15 selects an n-bit word using bits [n-1:0]. Exactly that many bit strobes complete a transfer.
- R2: Length codes 1, 2 and 3 are reserved. A start pulse with such a code is ignored: busy stays low and no done pulse follows.
- R3: With order select 0 (MSB-first), the serial output presents bit (length-1) of the transmit word first and bit 0 last. Each received bit is stored at the position it occupies in that same order.
- R4: With order select 1 (LSB-first), bit 0 is sent and received first, and the index rises by one per bit.
- R5: The received word is right-aligned, and every bit at or above the configured length reads zero.
- R6: Done is high for exactly one cycle, in the cycle after the clock edge that samples the last bit. The received word is valid in that cycle and busy is already low.
- R7: Length, order and transmit word are captured when a start is accepted. Changing those inputs during a transfer does not affect the word in flight.
- R8: A start pulse while busy is high is ignored.
- R9: The bit position advances only on a clock edge where the bit strobe is high. Between strobes the serial output and the busy flag hold.
- R10: After a synchronous reset, busy, done, the serial output and the received word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle and the length code is valid |
| len_code_i | input | 4 | Length code: 0 = 16 bits, 4..15 = that many bits, 1..3 reserved |
| lsb_first_i | input | 1 | Bit order: 0 = MSB-first, 1 = LSB-first |
| tx_word_i | input | 16 | Right-aligned transmit word |
| bit_en_i | input | 1 | Bit-slot strobe: one bit moves per strobed edge |
| sdi_i | input | 1 | Serial data in, sampled on strobed edges |
| sdo_o | output | 1 | Serial data out (registered) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the word completes |
| rx_word_o | output | 16 | Right-aligned received word, zero above the length |

## Verification
Several properties are checked on every cycle: done lasts one cycle and never coincides with busy; a reserved code never raises busy; received bits above the latched length are zero; and the serial output and bit position hold between strobes. Only the bench's scenarios can show that the right bit appears on the serial output in each slot, for both orders and for lengths 4, 16 and values in between. The same holds for complete received words matching the driven serial pattern, and for a word in flight being unaffected by changes to the configuration inputs or by a second start pulse.

// File: rtl/swl_pkg.sv
package swl_pkg;
  // Smallest legal word length; codes 1..MIN-1 are reserved
  localparam int unsigned SWL_MIN_LEN = 4;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } order_e;
endpackage

// File: rtl/swl_len_decode.sv
module swl_len_decode #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  len_o,
  output logic              valid_o
);
  import swl_pkg::*;

  logic [31:0] code_w;
  assign code_w = 32'(code_i);

  always_comb begin
    if (code_w == 32'd0) begin
      len_o   = CNT_W'(DATA_W);
      valid_o = 1'b1;
    end else begin
      len_o   = CNT_W'(code_w);
      valid_o = (code_w >= SWL_MIN_LEN) && (code_w < DATA_W);
    end
  end
endmodule

// File: rtl/swl_bit_sequencer.sv
module swl_bit_sequencer #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1),
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             lsb_first_i,
  input  logic             bit_en_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_nxt_o,
  output logic [CNT_W-1:0] len_q_o,
  output logic             busy_o,
  output logic             done_o
);
  import swl_pkg::*;

  logic             busy_q, done_q;
  logic [CNT_W-1:0] rem_q, len_q;
  logic [IDX_W-1:0] idx_q;
  order_e           order_q;

  assign load_o      = start_i && !busy_q && valid_i;
  assign step_o      = bit_en_i && busy_q;
  assign last_o      = (rem_q == CNT_W'(1));
  assign first_idx_o = lsb_first_i ? '0 : IDX_W'(len_i - CNT_W'(1));
  assign idx_nxt_o   = (order_q == ORDER_LSB) ? idx_q + IDX_W'(1) : idx_q - IDX_W'(1);
  assign idx_o       = idx_q;
  assign len_q_o     = len_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rem_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      order_q <= ORDER_MSB;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q  <= 1'b1;
        rem_q   <= len_i;
        len_q   <= len_i;
        idx_q   <= first_idx_o;
        order_q <= order_e'(lsb_first_i);
      end else if (step_o) begin
        rem_q <= rem_q - CNT_W'(1);
        idx_q <= idx_nxt_o;
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !bit_en_i |=> busy_q && $stable(idx_q));

  // R8
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && start_i |=> $stable(len_q) && $stable(order_q));
endmodule

// File: rtl/swl_shift_datapath.sv
module swl_shift_datapath #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  first_idx_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  idx_nxt_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] tx_q, rx_acc_q, rx_q;
  logic              sdo_q;
  logic [DATA_W-1:0] rx_with_bit;

  assign rx_with_bit = rx_acc_q | (DATA_W'(sdi_i) << idx_i);
  assign sdo_o       = sdo_q;
  assign rx_word_o   = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q     <= '0;
      rx_acc_q <= '0;
      rx_q     <= '0;
      sdo_q    <= 1'b0;
    end else if (load_i) begin
      tx_q     <= tx_word_i;
      rx_acc_q <= '0;
      sdo_q    <= tx_word_i[first_idx_i];
    end else if (step_i) begin
      rx_acc_q <= rx_with_bit;
      if (last_i) begin
        rx_q <= rx_with_bit;
      end else begin
        sdo_q <= tx_q[idx_nxt_i];
      end
    end
  end

  // R9
  sdo_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i && !step_i |=> $stable(sdo_q));

  // R7
  tx_latched_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(tx_q));
endmodule

// File: rtl/serial_word_shifter.sv
module serial_word_shifter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1),
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              lsb_first_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              bit_en_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [CNT_W-1:0] len_dec, len_q;
  logic             code_ok, load, step, last;
  logic [IDX_W-1:0] first_idx, idx, idx_nxt;

  swl_len_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dec (
    .code_i (len_code_i),
    .len_o  (len_dec),
    .valid_o(code_ok)
  );

  swl_bit_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .valid_i    (code_ok),
    .len_i      (len_dec),
    .lsb_first_i(lsb_first_i),
    .bit_en_i   (bit_en_i),
    .load_o     (load),
    .step_o     (step),
    .last_o     (last),
    .first_idx_o(first_idx),
    .idx_o      (idx),
    .idx_nxt_o  (idx_nxt),
    .len_q_o    (len_q),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  swl_shift_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .step_i     (step),
    .last_i     (last),
    .first_idx_i(first_idx),
    .idx_i      (idx),
    .idx_nxt_i  (idx_nxt),
    .tx_word_i  (tx_word_i),
    .sdi_i      (sdi_i),
    .sdo_o      (sdo_o),
    .rx_word_o  (rx_word_o)
  );

  // R2
  reserved_start_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && start_i && !code_ok |=> !busy_o);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((rx_word_o >> len_q) == '0));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: tb/serial_word_shifter_tb.sv
module serial_word_shifter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [3:0]  len_code_i = 4'd0;
  logic        lsb_first_i = 1'b0;
  logic [15:0] tx_word_i = 16'h0;
  logic        bit_en_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        sdo_o, busy_o, done_o;
  logic [15:0] rx_word_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_q[$];
  logic        done_prev = 1'b0;

  always #4 clk = ~clk;

  serial_word_shifter u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_code_i(len_code_i),
    .lsb_first_i(lsb_first_i), .tx_word_i(tx_word_i), .bit_en_i(bit_en_i),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o),
    .rx_word_o(rx_word_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected words on each done pulse (R5, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rx_word_o == e, "R5 rx word", int'(rx_word_o), int'(e));
          check(!busy_o, "R6 busy low at done", int'(busy_o), 0);
          check(!done_prev, "R6 done one cycle", int'(done_prev), 0);
        end
      end
      done_prev <= done_o;
    end
  end

  // Driver: one word transfer; gap = idle cycles between strobes,
  // disturb = change config inputs and re-pulse start mid-transfer
  task automatic run_word(input logic [15:0] tx, input logic [15:0] rxpat,
                          input logic [3:0] code, input bit lsb,
                          input int gap, input bit disturb);
    int len;
    logic [15:0] mask;
    len  = (code == 4'd0) ? 16 : int'(code);
    mask = (len == 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
    exp_q.push_back(rxpat & mask);
    start_i = 1'b1; len_code_i = code; lsb_first_i = lsb; tx_word_i = tx;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, "R1 busy after start", int'(busy_o), 1);
    if (disturb) begin
      len_code_i = 4'd5; lsb_first_i = ~lsb; tx_word_i = ~tx;
    end
    for (int i = 0; i < len; i++) begin
      int p;
      p = lsb ? i : (len - 1 - i);
      for (int g = 0; g < gap; g++) begin
        check(sdo_o == tx[p] && busy_o, "R9 hold between strobes", int'(sdo_o), int'(tx[p]));
        @(negedge clk);
      end
      check(sdo_o == tx[p], lsb ? "R4 sdo bit" : "R3 sdo bit", int'(sdo_o), int'(tx[p]));
      sdi_i = rxpat[p];
      bit_en_i = 1'b1;
      if (disturb && i == 1) start_i = 1'b1; // R8
      @(negedge clk);
      bit_en_i = 1'b0;
      start_i = 1'b0;
      if (i < len - 1) check(busy_o, "R1 busy mid word", int'(busy_o), 1);
    end
    check(done_o, "R6 done after last bit", int'(done_o), 1);
    @(negedge clk);
    check(exp_q.size() == 0, "R6 word delivered", exp_q.size(), 0);
    check(!busy_o && !done_o, "R8 no restart", int'(busy_o), 0);
    len_code_i = 4'd0; lsb_first_i = 1'b0;
  endtask

  initial begin
    #800000;
    check(1'b0, "watchdog", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10
    check(!busy_o && !done_o && !sdo_o && rx_word_o == 16'h0, "R10 reset state",
          int'({busy_o, done_o, sdo_o}), 0);
    // R1 R3 full 16-bit MSB-first
    run_word(16'hA5C3, 16'h5A3C, 4'd0, 1'b0, 0, 1'b0);
    // R4 16-bit LSB-first with gaps (R9)
    run_word(16'h8001, 16'hC00B, 4'd0, 1'b1, 2, 1'b0);
    // R1 R5 minimum length, upper bits ignored
    run_word(16'hFFF6, 16'hFFF9, 4'd4, 1'b0, 1, 1'b0);
    run_word(16'h123D, 16'hEEE2, 4'd4, 1'b1, 0, 1'b0);
    // R1 R3 R4 other lengths
    run_word(16'h7ABC, 16'hFFFF, 4'd15, 1'b0, 0, 1'b0);
    run_word(16'h0155, 16'h02AA, 4'd9, 1'b1, 1, 1'b0);
    // R7 R8 config change and second start mid-transfer
    run_word(16'h0B6D, 16'h0493, 4'd12, 1'b0, 1, 1'b1);
    run_word(16'h00C7, 16'hFF39, 4'd7, 1'b1, 0, 1'b1);
    // R2 reserved codes
    for (int c = 1; c < 4; c++) begin
      start_i = 1'b1; len_code_i = 4'(c);
      @(negedge clk);
      start_i = 1'b0;
      check(!busy_o, "R2 reserved code no busy", int'(busy_o), 0);
      bit_en_i = 1'b1;
      repeat (3) @(negedge clk);
      bit_en_i = 1'b0;
      check(!busy_o && !done_o, "R2 reserved code no done", int'(done_o), 0);
    end
    len_code_i = 4'd0;
    // valid transfer still works after reserved attempts
    run_word(16'hBEEF, 16'h1234, 4'd0, 1'b1, 0, 1'b0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule